// File: doc/BRIEF.md
# Warp Memory Miss Parking Unit

This block sits in the load/store stage of a SIMT pipeline that issues one warp of thread lanes per cycle. Each incoming warp arrives with a per-lane hit mask from the L1 cache and the lane data that hit. A warp whose lanes all hit goes straight to write-back. A warp with any missing lane is set aside in a waiting list, and later warps keep issuing with no stall.

The waiting list has one slot per warp ID. Refill responses from memory carry a warp ID, a lane mask and lane data, and fill the missing lanes of the parked warp. A scanner visits one slot per cycle in round-robin order. When the visited slot has data on every lane, the warp is sent to write-back. The write-back port is registered and shared between direct warps and released warps. A direct warp always wins that port.

Top module: `warp_miss_park`

## Requirements
- R1: After reset, `wb_valid_o` is 0, every slot is empty so `req_ready_o` is 1 for every warp ID, and the scan pointer sits at slot 0.
- R2: An accepted warp whose `req_hit_i` is all ones appears on write-back in the next cycle: `wb_valid_o`=1, `wb_src_o`=0, with its warp ID and request data.
- R3: An accepted warp with at least one 0 bit in `req_hit_i` produces no write-back. It occupies the slot of its warp ID, and requests for other free warp IDs are still accepted in the following cycles.
- R4: A parked warp is released only when every lane holds data. It leaves with `wb_src_o`=1. Its lanes carry the request data for lanes that hit and the refill data for lanes that missed. A partly refilled warp stays parked.
- R5: Refill lanes are written only into a parked slot and only into lanes still missing. A refill to an empty slot, or to lanes that already hold data, changes nothing.
- R6: When a direct warp and a release fall in the same cycle, the direct warp takes write-back. The scan pointer stays on the ready slot, and that slot is released in the next cycle. At most one warp reaches write-back per cycle.
- R7: `req_ready_o` is 0 while the slot of `req_wid_i` is occupied, which covers a full waiting list. It returns to 1 once that slot is released.
- R8: The scan pointer checks one slot per cycle: slot 0 at the first edge after reset, then ascending with wrap-around. It moves on whether or not the checked slot is released, and stays put only in the R6 case. Write-back is registered, so a release shows one cycle after the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp memory request present |
| req_ready_o | output | 1 | Request can be accepted (slot of `req_wid_i` free) |
| req_wid_i | input | $clog2(WARPS) | Warp ID of the request |
| req_hit_i | input | LANES | Per-lane hit, 1 = lane data valid |
| req_data_i | input | LANES*DW | Lane data, lane l in bits [l*DW +: DW] |
| fill_valid_i | input | 1 | Refill response present |
| fill_wid_i | input | $clog2(WARPS) | Warp ID of the refill |
| fill_mask_i | input | LANES | Lanes carried by the refill |
| fill_data_i | input | LANES*DW | Refill lane data |
| wb_valid_o | output | 1 | Warp presented to write-back |
| wb_wid_o | output | $clog2(WARPS) | Warp ID at write-back |
| wb_src_o | output | 1 | 0 = direct all-hit warp, 1 = released parked warp |
| wb_data_o | output | LANES*DW | Complete lane data |

## Verification
The bench builds the block with 4 warp slots, 4 lanes and 8-bit lane data. A scan round is then only four cycles long, and the exact cycle of every release can be worked out by hand from the reset edge. With only four slots, filling the whole waiting list and blocking on an occupied warp ID takes a few cycles. It also makes it cheap to line a direct warp up with a release in the same cycle. Lane data is built from the warp ID and lane number, so any mix-up of request and refill lanes shows in the write-back word.

// File: rtl/warp_park_pkg.sv
package warp_park_pkg;
  typedef enum logic {
    WB_SRC_DIRECT = 1'b0,
    WB_SRC_PARKED = 1'b1
  } wb_src_e;
endpackage

// File: rtl/wpk_entry.sv
module wpk_entry #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic [LANES-1:0]    alloc_hit_i,
  input  logic [LANES*DW-1:0] alloc_data_i,
  input  logic                fill_i,
  input  logic [LANES-1:0]    fill_mask_i,
  input  logic [LANES*DW-1:0] fill_data_i,
  input  logic                release_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [LANES*DW-1:0] data_o
);
  logic                busy_q;
  logic [LANES-1:0]    vmask_q;
  logic [LANES*DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      vmask_q <= '0;
      data_q  <= '0;
    end else if (release_i) begin
      busy_q  <= 1'b0;
      vmask_q <= '0;
    end else if (alloc_i) begin
      busy_q  <= 1'b1;
      vmask_q <= alloc_hit_i;
      data_q  <= alloc_data_i;
    end else if (fill_i && busy_q) begin
      vmask_q <= vmask_q | fill_mask_i;
      // write-once: lanes already holding data keep it
      for (int l = 0; l < LANES; l++)
        if (fill_mask_i[l] && !vmask_q[l])
          data_q[l*DW +: DW] <= fill_data_i[l*DW +: DW];
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (&vmask_q);
  assign data_o = data_q;

  assert_alloc_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q);
  assert_release_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> (busy_q && (&vmask_q)));
  assert_release_frees_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !busy_q);
endmodule

// File: rtl/wpk_rr_scan.sv
module wpk_rr_scan #(
  parameter int WARPS = 16,
  localparam int IDW  = $clog2(WARPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WARPS-1:0] done_i,
  input  logic             blocked_i,
  output logic             rel_o,
  output logic [IDW-1:0]   sel_o
);
  localparam logic [IDW-1:0] LAST = IDW'(WARPS - 1);

  logic [IDW-1:0] ptr_q;
  logic           hit_here;
  logic           hold;

  assign hit_here = done_i[ptr_q];
  assign rel_o    = hit_here && !blocked_i;
  assign hold     = hit_here && blocked_i;
  assign sel_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (!hold)           ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assert_rr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i[ptr_q] && blocked_i) |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
  assert_rr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i[ptr_q] && blocked_i) |=> $stable(ptr_q));
endmodule

// File: rtl/wpk_wb_mux.sv
module wpk_wb_mux
  import warp_park_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 32,
  parameter int IDW   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                direct_i,
  input  logic [IDW-1:0]      direct_wid_i,
  input  logic [LANES*DW-1:0] direct_data_i,
  input  logic                rel_i,
  input  logic [IDW-1:0]      rel_wid_i,
  input  logic [LANES*DW-1:0] rel_data_i,
  output logic                wb_valid_o,
  output logic [IDW-1:0]      wb_wid_o,
  output wb_src_e             wb_src_o,
  output logic [LANES*DW-1:0] wb_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_wid_o   <= '0;
      wb_src_o   <= WB_SRC_DIRECT;
      wb_data_o  <= '0;
    end else if (direct_i) begin
      wb_valid_o <= 1'b1;
      wb_wid_o   <= direct_wid_i;
      wb_src_o   <= WB_SRC_DIRECT;
      wb_data_o  <= direct_data_i;
    end else if (rel_i) begin
      wb_valid_o <= 1'b1;
      wb_wid_o   <= rel_wid_i;
      wb_src_o   <= WB_SRC_PARKED;
      wb_data_o  <= rel_data_i;
    end else begin
      wb_valid_o <= 1'b0;
    end
  end

  assert_one_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(direct_i && rel_i));
  assert_rel_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> (wb_valid_o && wb_src_o == WB_SRC_PARKED && wb_wid_o == $past(rel_wid_i)));
endmodule

// File: rtl/warp_miss_park.sv
module warp_miss_park
  import warp_park_pkg::*;
#(
  parameter int WARPS = 16,
  parameter int LANES = 16,
  parameter int DW    = 32,
  localparam int IDW  = $clog2(WARPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [IDW-1:0]      req_wid_i,
  input  logic [LANES-1:0]    req_hit_i,
  input  logic [LANES*DW-1:0] req_data_i,
  input  logic                fill_valid_i,
  input  logic [IDW-1:0]      fill_wid_i,
  input  logic [LANES-1:0]    fill_mask_i,
  input  logic [LANES*DW-1:0] fill_data_i,
  output logic                wb_valid_o,
  output logic [IDW-1:0]      wb_wid_o,
  output logic                wb_src_o,
  output logic [LANES*DW-1:0] wb_data_o
);
  logic [WARPS-1:0]               busy;
  logic [WARPS-1:0]               done;
  logic [WARPS-1:0][LANES*DW-1:0] slot_data;
  logic                           accept, all_hit, direct, park;
  logic                           rel;
  logic [IDW-1:0]                 sel;
  wb_src_e                        src;

  assign req_ready_o = !busy[req_wid_i];
  assign accept      = req_valid_i && req_ready_o;
  assign all_hit     = &req_hit_i;
  assign direct      = accept && all_hit;
  assign park        = accept && !all_hit;

  for (genvar w = 0; w < WARPS; w++) begin : g_slot
    wpk_entry #(.LANES(LANES), .DW(DW)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (park && (req_wid_i == IDW'(w))),
      .alloc_hit_i (req_hit_i),
      .alloc_data_i(req_data_i),
      .fill_i      (fill_valid_i && (fill_wid_i == IDW'(w))),
      .fill_mask_i (fill_mask_i),
      .fill_data_i (fill_data_i),
      .release_i   (rel && (sel == IDW'(w))),
      .busy_o      (busy[w]),
      .done_o      (done[w]),
      .data_o      (slot_data[w])
    );
  end

  wpk_rr_scan #(.WARPS(WARPS)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .blocked_i(direct),
    .rel_o    (rel),
    .sel_o    (sel)
  );

  wpk_wb_mux #(.LANES(LANES), .DW(DW), .IDW(IDW)) u_wb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .direct_i     (direct),
    .direct_wid_i (req_wid_i),
    .direct_data_i(req_data_i),
    .rel_i        (rel),
    .rel_wid_i    (sel),
    .rel_data_i   (slot_data[sel]),
    .wb_valid_o   (wb_valid_o),
    .wb_wid_o     (wb_wid_o),
    .wb_src_o     (src),
    .wb_data_o    (wb_data_o)
  );
  assign wb_src_o = src;

  assert_direct_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct |=> (wb_valid_o && !wb_src_o && wb_wid_o == $past(req_wid_i)
                && wb_data_o == $past(req_data_i)));
  assert_miss_parks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park |=> busy[$past(req_wid_i)]);
  assert_miss_no_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (park && !rel) |=> !wb_valid_o);
endmodule

// File: tb/warp_miss_park_tb_top.sv
module warp_miss_park_tb_top;
  localparam int WARPS = 4;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int IDW   = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [IDW-1:0]   req_wid_i = '0;
  logic [LANES-1:0] req_hit_i = '0;
  logic [LANES*DW-1:0] req_data_i = '0;
  logic             fill_valid_i = 1'b0;
  logic [IDW-1:0]   fill_wid_i = '0;
  logic [LANES-1:0] fill_mask_i = '0;
  logic [LANES*DW-1:0] fill_data_i = '0;
  logic             wb_valid_o;
  logic [IDW-1:0]   wb_wid_o;
  logic             wb_src_o;
  logic [LANES*DW-1:0] wb_data_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  warp_miss_park #(.WARPS(WARPS), .LANES(LANES), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_wid_i(req_wid_i),
    .req_hit_i(req_hit_i), .req_data_i(req_data_i),
    .fill_valid_i(fill_valid_i), .fill_wid_i(fill_wid_i),
    .fill_mask_i(fill_mask_i), .fill_data_i(fill_data_i),
    .wb_valid_o(wb_valid_o), .wb_wid_o(wb_wid_o), .wb_src_o(wb_src_o),
    .wb_data_o(wb_data_o)
  );

  // lane data patterns: request lane = {wid,lane}, refill lane has bit 7 set
  function automatic logic [LANES*DW-1:0] pat_req(input logic [IDW-1:0] w);
    logic [LANES*DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = 8'(({6'd0, w} << 4) | l);
    return v;
  endfunction
  function automatic logic [LANES*DW-1:0] pat_fill(input logic [IDW-1:0] w);
    logic [LANES*DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = 8'(8'h80 | ({6'd0, w} << 4) | l);
    return v;
  endfunction
  function automatic logic [LANES*DW-1:0] exp_data(input logic [IDW-1:0] w,
                                                   input logic [LANES-1:0] from_fill);
    logic [LANES*DW-1:0] r, f, v;
    r = pat_req(w);
    f = pat_fill(w);
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = from_fill[l] ? f[l*DW +: DW] : r[l*DW +: DW];
    return v;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [IDW-1:0] rw, input logic [LANES-1:0] rh,
                       input logic fv, input logic [IDW-1:0] fw, input logic [LANES-1:0] fm);
    req_valid_i  = rv;  req_wid_i = rw;  req_hit_i = rh;  req_data_i = pat_req(rw);
    fill_valid_i = fv;  fill_wid_i = fw; fill_mask_i = fm; fill_data_i = pat_fill(fw);
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, '0, '0);
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic check_wb(input logic ev, input logic [IDW-1:0] ew, input logic es,
                          input logic [LANES-1:0] ef, input string req);
    check(wb_valid_o == ev, req, 64'(wb_valid_o), 64'(ev));
    if (ev) begin
      check(wb_wid_o == ew, req, 64'(wb_wid_o), 64'(ew));
      check(wb_src_o == es, req, 64'(wb_src_o), 64'(es));
      check(wb_data_o == exp_data(ew, ef), req, 64'(wb_data_o), 64'(exp_data(ew, ef)));
    end
  endtask

  task automatic wait_wb();
    for (int k = 0; k < 16; k++) begin
      if (wb_valid_o) break;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic rv; logic [1:0] rw; logic [3:0] rh;
    logic fv; logic [1:0] fw; logic [3:0] fm;
    logic ev; logic [1:0] ew; logic es; logic [3:0] ef;
    logic erdy;
  } vec_t;

  // row i is driven before edge i after reset; scan pointer checks slot (i mod 4)
  localparam vec_t TBL [17] = '{
    '{1'b1,2'd1,4'b1110, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // park 1
    '{1'b1,2'd2,4'b1110, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // park 2
    '{1'b1,2'd3,4'b1110, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // park 3
    '{1'b0,2'd0,4'b0000, 1'b1,2'd3,4'b0001, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // fill 3
    '{1'b0,2'd0,4'b0000, 1'b1,2'd2,4'b0001, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // fill 2
    '{1'b0,2'd0,4'b0000, 1'b1,2'd1,4'b0001, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // fill 1
    '{1'b0,2'd0,4'b0000, 1'b0,2'd0,4'b0000, 1'b1,2'd2,1'b1,4'b0001, 1'b1}, // rel 2
    '{1'b0,2'd0,4'b0000, 1'b0,2'd0,4'b0000, 1'b1,2'd3,1'b1,4'b0001, 1'b1}, // rel 3
    '{1'b0,2'd0,4'b0000, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // slot 0 empty
    '{1'b0,2'd0,4'b0000, 1'b0,2'd0,4'b0000, 1'b1,2'd1,1'b1,4'b0001, 1'b1}, // rel 1
    '{1'b1,2'd0,4'b1111, 1'b0,2'd0,4'b0000, 1'b1,2'd0,1'b0,4'b0000, 1'b1}, // direct 0
    '{1'b1,2'd1,4'b1111, 1'b0,2'd0,4'b0000, 1'b1,2'd1,1'b0,4'b0000, 1'b1}, // direct 1
    '{1'b1,2'd0,4'b0111, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b1}, // park 0
    '{1'b1,2'd0,4'b1111, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b0}, // 0 busy
    '{1'b0,2'd0,4'b0000, 1'b1,2'd0,4'b1000, 1'b0,2'd0,1'b0,4'b0000, 1'b0}, // fill 0
    '{1'b0,2'd0,4'b0000, 1'b0,2'd0,4'b0000, 1'b0,2'd0,1'b0,4'b0000, 1'b0},
    '{1'b0,2'd0,4'b0000, 1'b0,2'd0,4'b0000, 1'b1,2'd0,1'b1,4'b1000, 1'b0}  // rel 0
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    check(wb_valid_o == 1'b0, "R1 wb_valid", 64'(wb_valid_o), 64'd0);
    for (int w = 0; w < WARPS; w++) begin
      req_wid_i = IDW'(w);
      #1 check(req_ready_o == 1'b1, "R1 ready", 64'(req_ready_o), 64'd1);
    end

    // table walk: R2 direct, R3 park without stall, R4 release, R7 busy slot, R8 scan order
    do_reset();
    for (int i = 0; i < 17; i++) begin
      if (i > 0) check_wb(TBL[i-1].ev, TBL[i-1].ew, TBL[i-1].es, TBL[i-1].ef,
                          $sformatf("R2/R3/R4/R8 row %0d", i-1));
      drive(TBL[i].rv, TBL[i].rw, TBL[i].rh, TBL[i].fv, TBL[i].fw, TBL[i].fm);
      #1 check(req_ready_o == TBL[i].erdy, $sformatf("R3/R7 ready row %0d", i),
               64'(req_ready_o), 64'(TBL[i].erdy));
      @(negedge clk);
    end
    check_wb(TBL[16].ev, TBL[16].ew, TBL[16].es, TBL[16].ef, "R4 row 16");
    idle();

    // R6: direct and release in the same cycle (slot 1 checked at edge 5)
    do_reset();
    drive(1'b1, 2'd1, 4'b1110, 1'b0, 2'd0, 4'b0000);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd1, 4'b0001);
    @(negedge clk);
    idle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(wb_valid_o == 1'b0, "R8 no early release", 64'(wb_valid_o), 64'd0);
    end
    drive(1'b1, 2'd2, 4'b1111, 1'b0, 2'd0, 4'b0000);
    @(negedge clk);
    idle();
    check_wb(1'b1, 2'd2, 1'b0, 4'b0000, "R6 direct wins");
    @(negedge clk);
    check_wb(1'b1, 2'd1, 1'b1, 4'b0001, "R6 parked next cycle");
    @(negedge clk);
    check(wb_valid_o == 1'b0, "R6 single release", 64'(wb_valid_o), 64'd0);

    // R4: partly refilled warp stays parked
    do_reset();
    drive(1'b1, 2'd0, 4'b1100, 1'b0, 2'd0, 4'b0000);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd0, 4'b0001);
    @(negedge clk);
    idle();
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        seen = seen | wb_valid_o;
      end
      check(seen == 1'b0, "R4 partial stays parked", 64'(seen), 64'd0);
    end
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd0, 4'b0010);
    @(negedge clk);
    idle();
    wait_wb();
    check_wb(1'b1, 2'd0, 1'b1, 4'b0011, "R4 complete after second refill");

    // R5: refill to filled lane and to empty slot ignored
    do_reset();
    drive(1'b1, 2'd1, 4'b1100, 1'b0, 2'd0, 4'b0000);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd1, 4'b0111);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd3, 4'b1111);
    @(negedge clk);
    idle();
    wait_wb();
    check_wb(1'b1, 2'd1, 1'b1, 4'b0011, "R5 filled lane kept");
    @(negedge clk);
    drive(1'b1, 2'd3, 4'b1110, 1'b0, 2'd0, 4'b0000);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd3, 4'b0001);
    @(negedge clk);
    idle();
    wait_wb();
    check_wb(1'b1, 2'd3, 1'b1, 4'b0001, "R5 stray refill ignored");

    // R7: full waiting list blocks every ID, released slot reopens
    do_reset();
    for (int w = 0; w < WARPS; w++) begin
      drive(1'b1, IDW'(w), 4'b1110, 1'b0, 2'd0, 4'b0000);
      @(negedge clk);
    end
    idle();
    for (int w = 0; w < WARPS; w++) begin
      req_wid_i = IDW'(w);
      #1 check(req_ready_o == 1'b0, "R7 full list", 64'(req_ready_o), 64'd0);
    end
    drive(1'b0, 2'd0, 4'b0000, 1'b1, 2'd2, 4'b0001);
    @(negedge clk);
    idle();
    wait_wb();
    check_wb(1'b1, 2'd2, 1'b1, 4'b0001, "R7 release from full list");
    req_wid_i = 2'd2;
    #1 check(req_ready_o == 1'b1, "R7 freed slot ready", 64'(req_ready_o), 64'd1);
    req_wid_i = 2'd0;
    #1 check(req_ready_o == 1'b0, "R7 other slot busy", 64'(req_ready_o), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule